// File: doc/BRIEF.md
# Three-Channel Timer Sound Generator

This block is a small sound source. It holds three programmable down-counters, and each counter drives a square-wave output. The three outputs are weighted by per-channel volumes and added into one signed sample. A processor writes the counter setup through an 8-bit, write-only register window of eight offsets. A second write port holds a 2-bit effect-control field and a 3-bit volume for each channel.

Counters advance only on cycles where the timer clock-enable `tick` is high. The mixed sample is registered only on cycles where `sample_en` is high. Each channel counts either every tick or on pulses from a noise source. The noise source is a 128-bit shift register with delayed-XOR feedback. A channel can count as one 16-bit counter or as two cascaded 8-bit counters. Channel 2 can also divide its incoming clocks by eight.

Top module: `tone_timer_mixer`

## Requirements
- R1: After reset the sample output is 0. All control, latch, counter, volume and effect registers are 0, every output state is low, and the noise register holds all ones.
- R2: A write to offset 1 loads channel 1 control. A write to offset 0 loads channel 0 control when channel 1 control bit 0 is 1, and channel 2 control when that bit is 0.
- R3: Offsets 2, 4 and 6 all write one shared high-byte holding register. A write to offset 3, 5 or 7 sets the 16-bit latch of channel 0, 1 or 2 to {high byte, written byte}. The latch is copied into the counter in the same cycle when control bit 4 is 0. When control bit 4 is 1, the counter picks up the new latch only at its next reload.
- R4: A channel counts only when control bit 7 is 1. It counts every tick when control bit 1 is 1. In 16-bit mode (control bit 2 = 0), a counter at 0 reloads from its latch and toggles the output state. With latch N, the output therefore changes every N+1 counts.
- R5: In dual 8-bit mode (control bit 2 = 1), the low byte counts down and reloads from the latch low byte after passing 0. Each such pass decrements the high byte, and the output goes high when the high byte reaches 0. A pass while the high byte is already 0 drives the output low and reloads the whole counter. With high byte H and low byte L, the output is high exactly when H > 0 and floor(k/(L+1)) mod (H+1) = H, where k is the number of counts.
- R6: When channel 2 control bit 0 is 1, channel 2 advances once per eight incoming clocks. The remainder carries over between ticks.
- R7: While channel 0 control bit 0 is 1, no counter, output state or noise step changes, and each registered sample is 0.
- R8: The noise register steps only while at least one channel has control bit 1 clear. On a step, the new feedback bit is bit 127 XOR bit 95. The bit shifted into position 0 is that feedback XOR the feedback of the previous step. A step whose shifted result has bit 64 = 1 and bit 65 = 0 sets a pending noise pulse. A channel with control bit 1 clear counts that pulse on the next tick.
- R9: Effect bit 0 = 0 steps the noise register on every tick. Effect bit 0 = 1 steps it once, in the cycle after channel 0's output rises. Effect bit 1 = 1 removes channel 0 from the mix.
- R10: On the effect port, address 0 writes the effect bits from data[1:0], and addresses 1, 2 and 3 write the volume of channel 0, 1 and 2 from data[2:0]. An enabled channel whose output is high adds floor(volume × BASE_LVL / 7) to the sample.
- R11: The sample output changes only on a clock edge with `sample_en` high, and then shows the mix of the states held before that edge. Output states change only on edges with `tick` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register window write strobe |
| wr_addr | input | 3 | Register window offset |
| wr_data | input | 8 | Register window write data |
| fx_wr_en | input | 1 | Effect/volume port write strobe |
| fx_addr | input | 2 | 0 effect bits, 1..3 channel volume |
| fx_data | input | 8 | Effect/volume write data |
| tick | input | 1 | Timer clock enable |
| sample_en | input | 1 | Sample register enable |
| sample_out | output | SAMP_W | Mixed signed sample |

## Verification
A wrong counter value, a wrong reload or a wrong mode decode shows up at `sample_out`. It moves a level edge by one or more ticks, and since each level edge is sampled one cycle after its tick, the error appears within one period of the programmed tone. The bench sweeps small latch values in both counting modes and in the prescaled mode, and it compares every step against closed-form phase formulas. A corrupted noise register changes which ticks move a noise-clocked channel, and a lock-step arithmetic model of the shift register exposes that within a few hundred ticks. Steering and volume faults show as wrong sums, because each channel is given a distinct weight.

// File: rtl/tone_timer_mixer.sv
module tone_timer_mixer #(
  parameter int SAMP_W   = 16,
  parameter int BASE_LVL = 5461,
  parameter int NOISE_W  = 128,
  parameter int PRE_LOG2 = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     fx_wr_en,
  input  logic [1:0]               fx_addr,
  input  logic [7:0]               fx_data,
  input  logic                     tick,
  input  logic                     sample_en,
  output logic signed [SAMP_W-1:0] sample_out
);
  localparam int NCH    = 3;
  localparam int TAP_HI = NOISE_W - 1;
  localparam int TAP_LO = NOISE_W - 33;
  localparam int PLS    = NOISE_W / 2;

  logic [NCH-1:0][7:0]  ctl_all;
  logic [NCH-1:0][15:0] cnt_all;
  logic [NCH-1:0]       st_all, st_nx_all;
  logic [NCH-1:0][2:0]  vol_q;
  logic [1:0]           fx_q;
  logic [7:0]           msb_q;
  logic [NOISE_W-1:0]   nz;
  logic                 nz_old, nz_pend, ch0_rise;
  logic [SAMP_W-1:0]    mix;
  logic                 unused_fx;

  wire hold    = ctl_all[0][0];
  wire run     = tick && !hold;
  wire noisy   = !(ctl_all[0][1] && ctl_all[1][1] && ctl_all[2][1]);
  wire nz_step = noisy && !hold && (fx_q[0] ? ch0_rise : tick);
  wire nz_fb   = nz[TAP_HI] ^ nz[TAP_LO];
  wire nz_gen  = nz[PLS-1] & ~nz[PLS];
  wire [2:0] ctl0_tgt = ctl_all[1][0] ? 3'd0 : 3'd2;

  assign unused_fx = ^fx_data[7:3];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [7:0]  ctl_q;
    logic [15:0] lat_q, cnt_q, cnt_nx;
    logic        st_q, st_nx, clk_in, adv, ctl_we, lat_we;
    logic        unused_ctl;

    assign unused_ctl = ^{ctl_q[6:5], ctl_q[3]};
    assign ctl_we = wr_en && ((wr_addr == 3'd1 && g == 1) ||
                              (wr_addr == 3'd0 && ctl0_tgt == 3'(g)));
    assign lat_we = wr_en && wr_addr[0] && (wr_addr[2:1] == 2'(g + 1));
    assign clk_in = ctl_q[7] && run && (ctl_q[1] || nz_pend);

    if (g == 2) begin : g_pre
      logic [PRE_LOG2-1:0] pre_q;
      assign adv = clk_in && (!ctl_q[0] || pre_q == '1);
      always_ff @(posedge clk) begin
        if (!rst_n)                  pre_q <= '0;
        else if (clk_in && ctl_q[0]) pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign adv = clk_in;
    end

    always_comb begin
      cnt_nx = cnt_q;
      st_nx  = st_q;
      if (adv) begin
        if (ctl_q[2]) begin
          if (cnt_q[7:0] == 8'd0) begin
            if (cnt_q[15:8] == 8'd0) begin
              cnt_nx = lat_q;
              st_nx  = 1'b0;
            end else begin
              cnt_nx = {cnt_q[15:8] - 8'd1, lat_q[7:0]};
              if (cnt_q[15:8] == 8'd1) st_nx = 1'b1;
            end
          end else begin
            cnt_nx[7:0] = cnt_q[7:0] - 8'd1;
          end
        end else if (cnt_q == 16'd0) begin
          cnt_nx = lat_q;
          st_nx  = ~st_q;
        end else begin
          cnt_nx = cnt_q - 16'd1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q <= '0;
        lat_q <= '0;
        cnt_q <= '0;
        st_q  <= 1'b0;
      end else begin
        if (ctl_we) ctl_q <= wr_data;
        st_q <= st_nx;
        if (lat_we) begin
          lat_q <= {msb_q, wr_data};
          cnt_q <= ctl_q[4] ? cnt_nx : {msb_q, wr_data};
        end else begin
          cnt_q <= cnt_nx;
        end
      end
    end

    assign ctl_all[g]   = ctl_q;
    assign cnt_all[g]   = cnt_q;
    assign st_all[g]    = st_q;
    assign st_nx_all[g] = st_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msb_q <= '0;
      fx_q  <= '0;
      vol_q <= '0;
    end else begin
      if (wr_en && wr_addr != 3'd0 && !wr_addr[0]) msb_q <= wr_data;
      if (fx_wr_en) begin
        if (fx_addr == 2'd0) fx_q <= fx_data[1:0];
        else                 vol_q[fx_addr - 2'd1] <= fx_data[2:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nz       <= '1;
      nz_old   <= 1'b0;
      nz_pend  <= 1'b0;
      ch0_rise <= 1'b0;
    end else begin
      ch0_rise <= !st_all[0] && st_nx_all[0];
      if (nz_step) begin
        nz      <= {nz[NOISE_W-2:0], nz_fb ^ nz_old};
        nz_old  <= nz_fb;
        nz_pend <= nz_gen;
      end else if (run) begin
        nz_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    int acc;
    acc = 0;
    for (int i = 0; i < NCH; i++)
      if (ctl_all[i][7] && st_all[i] && !(i == 0 && fx_q[1]))
        acc += (int'(vol_q[i]) * BASE_LVL) / 7;
    mix = SAMP_W'(acc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         sample_out <= '0;
    else if (sample_en) sample_out <= hold ? '0 : $signed(mix);
  end
endmodule

// File: rtl/tone_timer_mixer_chk.sv
module tone_timer_mixer_chk #(
  parameter int SAMP_W  = 16,
  parameter int NOISE_W = 128
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     tick,
  input logic                     sample_en,
  input logic signed [SAMP_W-1:0] sample_out,
  input logic                     hold,
  input logic [2:0][7:0]          ctl_all,
  input logic [2:0][15:0]         cnt_all,
  input logic [2:0]               st_all,
  input logic [NOISE_W-1:0]       nz
);
  a_r7_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && sample_en) |=> sample_out == '0);

  a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> ($stable(cnt_all) && $stable(st_all)));

  a_r11_sample_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(sample_out));

  a_r11_tick_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(st_all));

  a_r8_noise_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_all[0][1] && ctl_all[1][1] && ctl_all[2][1]) |=> $stable(nz));
endmodule

bind tone_timer_mixer tone_timer_mixer_chk #(.SAMP_W(SAMP_W), .NOISE_W(NOISE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .sample_en(sample_en),
  .sample_out(sample_out), .hold(ctl_all[0][0]), .ctl_all(ctl_all),
  .cnt_all(cnt_all), .st_all(st_all), .nz(nz)
);

// File: tb/tone_timer_mixer_tb.sv
module tone_timer_mixer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, fx_wr_en = 1'b0, tick = 1'b0, sample_en = 1'b1;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0, fx_data = '0;
  logic [1:0] fx_addr = '0;
  logic signed [15:0] sample_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tone_timer_mixer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fx_wr_en(fx_wr_en), .fx_addr(fx_addr), .fx_data(fx_data),
    .tick(tick), .sample_en(sample_en), .sample_out(sample_out)
  );

  function automatic int lvl(input int v);
    return v * 5461 / 7;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_s(input string tag, input int exp);
    chk(int'(sample_out) == exp, tag, int'(sample_out), exp);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic fx(input int a, input int d);
    @(negedge clk);
    fx_wr_en = 1'b1; fx_addr = 2'(a); fx_data = 8'(d);
    @(negedge clk) fx_wr_en = 1'b0;
  endtask

  task automatic step();
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk_s("R1 reset sample", 0);

    for (int v = 0; v < 8; v++) begin
      do_reset();
      fx(2, v); wr(1, 8'h82); wr(2, 0); wr(5, 0);
      step();
      chk_s("R10 volume level", lvl(v));
    end

    for (int n = 0; n < 7; n++) begin
      do_reset();
      fx(2, 7); wr(1, 8'h82); wr(2, 0); wr(5, n);
      for (int k = 1; k <= 2 * (n + 1) + 1; k++) begin
        step();
        chk_s("R4 16-bit phase", ((k / (n + 1)) % 2) ? lvl(7) : 0);
      end
    end

    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 3; l++) begin
        do_reset();
        fx(2, 7); wr(1, 8'h86); wr(6, h); wr(5, l);
        for (int k = 1; k <= 2 * (h + 1) * (l + 1); k++) begin
          step();
          chk_s("R5 dual 8-bit phase / R3 shared high byte",
                (h > 0 && ((k / (l + 1)) % (h + 1)) == h) ? lvl(7) : 0);
        end
      end

    do_reset();
    fx(3, 7); wr(0, 8'h83); wr(4, 0); wr(7, 1);
    for (int k = 1; k <= 40; k++) begin
      step();
      chk_s("R6 prescale by 8", (((k / 8) / 2) % 2) ? lvl(7) : 0);
    end

    do_reset();
    fx(1, 1); fx(2, 2); fx(3, 4);
    wr(0, 8'h82); wr(2, 0); wr(7, 0); wr(3, 0);
    step();
    chk_s("R2 offset 0 reaches channel 2", lvl(4));
    step();
    chk_s("R2 channel 2 toggles back", 0);
    wr(1, 8'h01); wr(0, 8'h82);
    step();
    chk_s("R2 offset 0 reaches channel 0", lvl(1) + lvl(4));

    do_reset();
    fx(3, 7); wr(0, 8'h82); wr(2, 0); wr(7, 2);
    for (int k = 1; k <= 3; k++) step();
    chk_s("R4 before hold", lvl(7));
    wr(1, 8'h01); wr(0, 8'h01);
    @(negedge clk);
    chk_s("R7 held sample", 0);
    repeat (5) step();
    chk_s("R7 held after ticks", 0);
    wr(0, 8'h00);
    @(negedge clk);
    chk_s("R7 state frozen through hold", lvl(7));
    step(); step();
    chk_s("R7 phase resumes", lvl(7));
    step();
    chk_s("R7 phase resumes toggle", 0);

    do_reset();
    fx(2, 7); wr(1, 8'h82); wr(2, 0); wr(5, 2);
    wr(1, 8'h92); wr(5, 10);
    for (int k = 1; k <= 14; k++) begin
      step();
      if (k == 2)  chk_s("R3 deferred old count low", 0);
      if (k == 3)  chk_s("R3 deferred old count toggles", lvl(7));
      if (k == 13) chk_s("R3 new latch after reload", lvl(7));
      if (k == 14) chk_s("R3 new latch period", 0);
    end
    do_reset();
    fx(2, 7); wr(1, 8'h82); wr(2, 0); wr(5, 5);
    step(); step();
    wr(5, 0);
    step();
    chk_s("R3 immediate counter load", lvl(7));

    do_reset();
    fx(1, 7); wr(1, 8'h01); wr(0, 8'h82); wr(2, 0); wr(3, 0);
    step();
    chk_s("R9 ch0 unmuted", lvl(7));
    fx(0, 2);
    @(negedge clk);
    chk_s("R9 ch0 muted", 0);
    fx(0, 0);
    @(negedge clk);
    chk_s("R9 ch0 unmuted again", lvl(7));

    begin
      logic [127:0] m;
      logic mo, mp, ms, g, nx;
      int toggles;
      do_reset();
      fx(2, 7); wr(1, 8'h80); wr(2, 0); wr(5, 0);
      m = '1; mo = 0; mp = 0; ms = 0; toggles = 0;
      for (int k = 0; k < 400; k++) begin
        step();
        if (mp) begin ms = ~ms; toggles++; end
        g = m[63] & ~m[64];
        nx = m[127] ^ m[95];
        m = {m[126:0], nx ^ mo};
        mo = nx; mp = g;
        chk_s("R8 noise-clocked channel", ms ? lvl(7) : 0);
      end
      chk(toggles > 0, "R8 noise pulses seen", toggles, 1);
    end

    begin
      logic [127:0] m;
      logic mo, mp, s0, s1, g, nx;
      int toggles;
      do_reset();
      fx(0, 3); fx(2, 7);
      wr(1, 8'h01); wr(0, 8'h82); wr(1, 8'h81);
      wr(2, 0); wr(3, 0); wr(5, 0);
      m = '1; mo = 0; mp = 0; s0 = 0; s1 = 0; toggles = 0;
      for (int k = 0; k < 600; k++) begin
        step();
        if (mp) begin s1 = ~s1; toggles++; end
        mp = 0;
        s0 = ~s0;
        if (s0) begin
          g = m[63] & ~m[64];
          nx = m[127] ^ m[95];
          m = {m[126:0], nx ^ mo};
          mo = nx; mp = g;
        end
        chk_s("R9 noise stepped by ch0 rise", s1 ? lvl(7) : 0);
      end
      chk(toggles > 0, "R9 ch0-driven noise pulses seen", toggles, 1);
    end

    do_reset();
    fx(2, 7); wr(1, 8'h82); wr(2, 0); wr(5, 0);
    sample_en = 1'b0;
    step();
    chk_s("R11 sample held without enable", 0);
    sample_en = 1'b1;
    @(negedge clk);
    chk_s("R11 sample updates with enable", lvl(7));
    repeat (6) @(negedge clk);
    chk_s("R11 no tick no change", lvl(7));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule